// File: doc/BRIEF.md
# Redundant-Copy Majority Table Extractor

This block rebuilds a small table of read-retry register values from a byte buffer that was read out of an unreliable one-time-programmable area. Every quantity in the buffer is stored eight times. The mode count and the register count are stored as plain copies. Each table value is stored as eight normal copies and eight bitwise-inverted copies. The block fetches the eight copies of each quantity through a byte read port and decides each one by a majority vote. If the normal copies of a value give no winner, it votes the inverted copies and complements the winner. The recovered values go out through a table write port.

A controller pulses `start` once the buffer is in place, then waits for `done`. If `error` is low when `done` pulses, the table is complete and `nmodes` and `nregs` describe its shape. The NAND device access that fills the buffer is handled elsewhere.

Top module: `vote_table_extract`

## Requirements
- R1: A vote looks at eight samples with indices 0..7 and tries only samples 0..3 as candidates. A candidate wins when more than four samples at higher indices equal it. The lowest-index winner is the result.
- R2: A value that appears in five samples or fewer never wins. When no candidate wins, the vote fails.
- R3: The mode count is voted from buffer bytes 0..7 and the register count from bytes 8..15. A failed count vote ends the job with `error` high and no table writes.
- R4: Copy k (0..7) of entry e is at byte 16 + (2k + v)·S + e, where S = nmodes·nregs, v = 0 for normal copies and v = 1 for inverted copies.
- R5: Inverted copies of an entry are read only when its normal vote fails. Their winner is written out bitwise complemented.
- R6: If both votes of an entry fail, the job ends with `done` and `error` both high, and no later entry is written.
- R7: Entry e = mode·nregs + reg is written at `tbl_addr` = e, with modes in the outer loop and registers in the inner loop. Each entry is written exactly once, in increasing address order.
- R8: If nmodes·nregs exceeds MAX_ENT (default 64), the job ends with `error` and no writes. A product of zero ends the job without error and without writes. A product equal to MAX_ENT is accepted.
- R9: `done` is high for exactly one cycle per job. `error`, `nmodes` and `nregs` hold their values until the next `start`, and `start` clears `error` on the next clock edge.
- R10: The buffer responds on `rd_data` one cycle after a cycle with `rd_en` high. `rd_en` is low whenever the block is idle.
- R11: While reset is held, and after it, `done`, `error`, `tbl_we` and `rd_en` are low and `nmodes` and `nregs` are zero. A reset in the middle of a job aborts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a job. Ignored while a job runs |
| rd_en | output | 1 | Buffer read strobe |
| rd_addr | output | ADDR_W | Buffer byte address |
| rd_data | input | DATA_W | Buffer byte, one cycle after `rd_en` |
| tbl_we | output | 1 | Table write strobe |
| tbl_addr | output | TBL_AW | Table entry index |
| tbl_data | output | DATA_W | Recovered entry value |
| nmodes | output | DATA_W | Voted mode count |
| nregs | output | DATA_W | Voted register count |
| done | output | 1 | One-cycle end-of-job pulse |
| error | output | 1 | Job aborted; held until next start |

## Verification
Each vote takes ten cycles: eight read cycles, one cycle to capture the last byte, and one decision cycle. A table write appears in the decision cycle of its entry, and `done` follows one cycle after the last decision. The bench therefore polls on every falling edge after `start` instead of predicting absolute cycle numbers. At each edge it records every `tbl_we` together with its index to check ordering. It samples `done`, `error` and the counts on the edge where `done` is high, and checks that `done` has fallen on the next edge. The clearing of `error` is checked on the first falling edge after the edge that samples `start`.

// File: rtl/vtx_pkg.sv
package vtx_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_VOTE} vtx_state_e;
  typedef enum logic [1:0] {PH_MODES, PH_REGS, PH_VALUES} vtx_phase_e;
endpackage

// File: rtl/vtx_vote.sv
// Majority vote over NCOPY samples; only the first half are candidates.
module vtx_vote #(
  parameter int DATA_W = 8,
  parameter int NCOPY  = 8
) (
  input  logic [NCOPY-1:0][DATA_W-1:0] samples,
  output logic                         win,
  output logic [DATA_W-1:0]            value
);
  localparam int HALF = NCOPY / 2;

  logic [HALF-1:0] hit;

  for (genvar gi = 0; gi < HALF; gi++) begin : g_cand
    logic [NCOPY-1:0] later_eq;
    for (genvar gj = 0; gj < NCOPY; gj++) begin : g_cmp
      if (gj > gi) begin : g_later
        assign later_eq[gj] = (samples[gj] == samples[gi]);
      end else begin : g_early
        assign later_eq[gj] = 1'b0;
      end
    end
    assign hit[gi] = ($countones(later_eq) > HALF);
  end

  // lowest-index winner takes priority
  always_comb begin
    win   = 1'b0;
    value = '0;
    for (int i = HALF - 1; i >= 0; i--) begin
      if (hit[i]) begin
        win   = 1'b1;
        value = samples[i];
      end
    end
  end
endmodule

// File: rtl/vtx_addr.sv
// Buffer address for copy `copy` of the quantity selected by phase.
module vtx_addr
  import vtx_pkg::*;
#(
  parameter int NCOPY  = 8,
  parameter int ADDR_W = 12,
  parameter int SET_W  = 16,
  parameter int TBL_AW = 6,
  parameter int CW     = $clog2(NCOPY)
) (
  input  vtx_phase_e        phase,
  input  logic [CW-1:0]     copy,
  input  logic              inv,
  input  logic [SET_W-1:0]  set_size,
  input  logic [TBL_AW-1:0] idx,
  output logic [ADDR_W-1:0] addr
);
  always_comb begin
    case (phase)
      PH_MODES: addr = ADDR_W'(copy);
      PH_REGS:  addr = ADDR_W'(NCOPY) + ADDR_W'(copy);
      default:  addr = ADDR_W'(2 * NCOPY)
                     + ADDR_W'({copy, inv}) * ADDR_W'(set_size)
                     + ADDR_W'(idx);
    endcase
  end
endmodule

// File: rtl/vote_table_extract.sv
module vote_table_extract
  import vtx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int NCOPY   = 8,
  parameter int ADDR_W  = 12,
  parameter int MAX_ENT = 64,
  parameter int TBL_AW  = $clog2(MAX_ENT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic              tbl_we,
  output logic [TBL_AW-1:0] tbl_addr,
  output logic [DATA_W-1:0] tbl_data,
  output logic [DATA_W-1:0] nmodes,
  output logic [DATA_W-1:0] nregs,
  output logic              done,
  output logic              error
);
  localparam int KW    = $clog2(NCOPY + 1);
  localparam int CW    = $clog2(NCOPY);
  localparam int SET_W = 2 * DATA_W;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_n_int;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_n_int = rsync_q[1];

  vtx_state_e                  state_q, state_d;
  vtx_phase_e                  phase_q, phase_d;
  logic [KW-1:0]               k_q, k_d;
  logic                        inv_q, inv_d;
  logic [DATA_W-1:0]           mode_q, mode_d, reg_q, reg_d;
  logic [DATA_W-1:0]           nmodes_q, nmodes_d, nregs_q, nregs_d;
  logic [TBL_AW-1:0]           idx_q, idx_d;
  logic [SET_W-1:0]            set_q, set_d;
  logic                        done_q, done_d, err_q, err_d;
  logic [NCOPY-1:0][DATA_W-1:0] samp_q, samp_d;
  logic                        cap_en;
  logic [CW-1:0]               cap_idx;
  logic                        vote_win;
  logic [DATA_W-1:0]           vote_val;
  logic [SET_W-1:0]            prod;

  vtx_vote #(.DATA_W(DATA_W), .NCOPY(NCOPY)) u_vote (
    .samples (samp_q),
    .win     (vote_win),
    .value   (vote_val)
  );

  vtx_addr #(.NCOPY(NCOPY), .ADDR_W(ADDR_W), .SET_W(SET_W), .TBL_AW(TBL_AW)) u_addr (
    .phase    (phase_q),
    .copy     (k_q[CW-1:0]),
    .inv      (inv_q),
    .set_size (set_q),
    .idx      (idx_q),
    .addr     (rd_addr)
  );

  assign rd_en   = (state_q == ST_FETCH) && (k_q < KW'(NCOPY));
  assign cap_en  = (state_q == ST_FETCH) && (k_q != '0);
  assign cap_idx = CW'(k_q - KW'(1));
  assign prod    = SET_W'(nmodes_q) * SET_W'(vote_val);

  always_comb begin
    samp_d = samp_q;
    if (cap_en) samp_d[cap_idx] = rd_data;
  end

  always_comb begin
    state_d  = state_q;
    phase_d  = phase_q;
    k_d      = k_q;
    inv_d    = inv_q;
    mode_d   = mode_q;
    reg_d    = reg_q;
    nmodes_d = nmodes_q;
    nregs_d  = nregs_q;
    idx_d    = idx_q;
    set_d    = set_q;
    err_d    = err_q;
    done_d   = 1'b0;
    tbl_we   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d  = ST_FETCH;
          phase_d  = PH_MODES;
          k_d      = '0;
          inv_d    = 1'b0;
          mode_d   = '0;
          reg_d    = '0;
          idx_d    = '0;
          set_d    = '0;
          nmodes_d = '0;
          nregs_d  = '0;
          err_d    = 1'b0;
        end
      end
      ST_FETCH: begin
        if (k_q == KW'(NCOPY)) state_d = ST_VOTE;
        else                   k_d     = k_q + KW'(1);
      end
      default: begin // ST_VOTE
        k_d     = '0;
        state_d = ST_FETCH;
        case (phase_q)
          PH_MODES: begin
            if (vote_win) begin
              nmodes_d = vote_val;
              phase_d  = PH_REGS;
            end else begin
              err_d = 1'b1; done_d = 1'b1; state_d = ST_IDLE;
            end
          end
          PH_REGS: begin
            if (!vote_win || prod > SET_W'(MAX_ENT)) begin
              if (vote_win) nregs_d = vote_val;
              err_d = 1'b1; done_d = 1'b1; state_d = ST_IDLE;
            end else begin
              nregs_d = vote_val;
              set_d   = prod;
              phase_d = PH_VALUES;
              if (prod == '0) begin
                done_d = 1'b1; state_d = ST_IDLE;
              end
            end
          end
          default: begin // PH_VALUES
            if (vote_win) begin
              tbl_we = 1'b1;
              inv_d  = 1'b0;
              idx_d  = idx_q + TBL_AW'(1);
              if (reg_q == nregs_q - DATA_W'(1)) begin
                reg_d  = '0;
                mode_d = mode_q + DATA_W'(1);
                if (mode_q == nmodes_q - DATA_W'(1)) begin
                  done_d = 1'b1; state_d = ST_IDLE;
                end
              end else begin
                reg_d = reg_q + DATA_W'(1);
              end
            end else if (!inv_q) begin
              inv_d = 1'b1;
            end else begin
              err_d = 1'b1; done_d = 1'b1; state_d = ST_IDLE;
            end
          end
        endcase
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      state_q  <= ST_IDLE;
      phase_q  <= PH_MODES;
      k_q      <= '0;
      inv_q    <= 1'b0;
      mode_q   <= '0;
      reg_q    <= '0;
      nmodes_q <= '0;
      nregs_q  <= '0;
      idx_q    <= '0;
      set_q    <= '0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      phase_q  <= phase_d;
      k_q      <= k_d;
      inv_q    <= inv_d;
      mode_q   <= mode_d;
      reg_q    <= reg_d;
      nmodes_q <= nmodes_d;
      nregs_q  <= nregs_d;
      idx_q    <= idx_d;
      set_q    <= set_d;
      done_q   <= done_d;
      err_q    <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int)  samp_q <= '0;
    else if (cap_en) samp_q <= samp_d;
  end

  assign tbl_addr = idx_q;
  assign tbl_data = inv_q ? ~vote_val : vote_val;
  assign nmodes   = nmodes_q;
  assign nregs    = nregs_q;
  assign done     = done_q;
  assign error    = err_q;
endmodule

// File: rtl/vote_table_extract_chk.sv
module vote_table_extract_chk #(
  parameter int DATA_W  = 8,
  parameter int MAX_ENT = 64,
  parameter int TBL_AW  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_en,
  input logic              tbl_we,
  input logic [TBL_AW-1:0] tbl_addr,
  input logic [DATA_W-1:0] nmodes,
  input logic [DATA_W-1:0] nregs,
  input logic              done,
  input logic              error
);
  localparam int PW = 2 * DATA_W;

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_no_write_on_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_we |-> (!error && !done));

  p_error_with_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(error) |-> done);

  p_bound_ok_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !error) |-> (PW'(nmodes) * PW'(nregs) <= PW'(MAX_ENT)));

  p_index_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_we |=> (tbl_addr == TBL_AW'($past(tbl_addr) + TBL_AW'(1))));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !rd_en);
endmodule

bind vote_table_extract vote_table_extract_chk #(
  .DATA_W(DATA_W), .MAX_ENT(MAX_ENT), .TBL_AW(TBL_AW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .tbl_we(tbl_we),
  .tbl_addr(tbl_addr), .nmodes(nmodes), .nregs(nregs),
  .done(done), .error(error)
);

// File: tb/vote_table_extract_tb.sv
`timescale 1ns/1ps
module vote_table_extract_tb;
  localparam int DATA_W = 8, NCOPY = 8, ADDR_W = 12, MAX_ENT = 64, TBL_AW = 6;

  logic clk, rst_n, start;
  logic rd_en, tbl_we, done, error;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] rd_data, tbl_data, nmodes, nregs;
  logic [TBL_AW-1:0] tbl_addr;

  vote_table_extract #(.DATA_W(DATA_W), .NCOPY(NCOPY), .ADDR_W(ADDR_W),
                       .MAX_ENT(MAX_ENT)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_data(tbl_data),
    .nmodes(nmodes), .nregs(nregs), .done(done), .error(error));

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [7:0] mem [0:4095];
  always @(posedge clk) if (rd_en) rd_data <= mem[rd_addr];

  int total = 0, bad = 0;
  int wr_cnt, seq_bad;
  logic [7:0] wr_val [0:63];
  logic err_first;

  // vector: {win, value, samples (byte i at [8i+:8])}
  localparam logic [72:0] VECS [0:7] = '{
    {1'b1, 8'h03, 64'h0303030303030303},
    {1'b1, 8'h05, 64'h2211050505050505},
    {1'b0, 8'h00, 64'h0707070707090201},
    {1'b1, 8'h09, 64'h0909090909090201},
    {1'b1, 8'h0A, 64'h0A0A0A0A0A0A0A0B},
    {1'b0, 8'h00, 64'h040302010C0C0C0C},
    {1'b0, 8'h00, 64'h0D0D0D0D0302010D},
    {1'b1, 8'h0E, 64'h0E0E0E0E0E02010E}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ev(input int e);
    return 8'(8'h30 + e * 5);
  endfunction

  task automatic clear_mem();
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
  endtask

  task automatic put_counts(input logic [63:0] m, input logic [63:0] r);
    for (int k = 0; k < 8; k++) begin
      mem[k]     = m[8*k +: 8];
      mem[8 + k] = r[8*k +: 8];
    end
  endtask

  task automatic put_copies(input int e, input int set, input int inv, input logic [63:0] s);
    for (int k = 0; k < 8; k++) mem[16 + (2*k + inv)*set + e] = s[8*k +: 8];
  endtask

  // fill all entries: normal copies right, inverted copies decoy
  task automatic fill_table(input int set);
    for (int e = 0; e < set; e++) begin
      put_copies(e, set, 0, {8{ev(e)}});
      put_copies(e, set, 1, {8{8'hA5}});
    end
  endtask

  task automatic run_job();
    bit got;
    got = 0;
    wr_cnt = 0;
    seq_bad = 0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    err_first = error;
    for (int c = 0; c < 5000; c++) begin
      if (tbl_we) begin
        if (int'(tbl_addr) != wr_cnt) seq_bad++;
        wr_val[tbl_addr] = tbl_data;
        wr_cnt++;
      end
      if (done) begin
        got = 1;
        break;
      end
      @(negedge clk);
    end
    chk(got, "watchdog: done not seen", 0, 1);
  endtask

  initial begin
    start = 1'b0;
    rst_n = 1'b0;
    clear_mem();
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(!done && !error && !tbl_we && !rd_en, "R11 outputs low in reset", {done, error, tbl_we, rd_en}, 0);
    chk(nmodes == 0 && nregs == 0, "R11 counts zero in reset", nmodes + nregs, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!rd_en && !done, "R10 R11 idle after reset", {rd_en, done}, 0);

    // vote table through the mode-count field (register count 0 => empty table)
    for (int v = 0; v < 8; v++) begin
      clear_mem();
      put_counts(VECS[v][63:0], 64'h0);
      run_job();
      chk(error == !VECS[v][72], $sformatf("R1 R2 R3 vector %0d error", v), error, !VECS[v][72]);
      if (VECS[v][72])
        chk(nmodes == VECS[v][71:64], $sformatf("R1 vector %0d nmodes", v), nmodes, VECS[v][71:64]);
      chk(wr_cnt == 0, "R8 zero product writes nothing", wr_cnt, 0);
    end

    // full 3x4 table, one entry from inverted copies, one with noisy copies
    clear_mem();
    put_counts({{7{8'h03}}, 8'h77}, {8'h55, {7{8'h04}}});
    fill_table(12);
    put_copies(5, 12, 0, 64'h8877665544332211);
    put_copies(5, 12, 1, {8{~ev(5)}});
    put_copies(7, 12, 0, {{6{ev(7)}}, 8'h99, 8'h98});
    run_job();
    chk(!error, "R4 table job no error", error, 0);
    chk(nmodes == 3 && nregs == 4, "R3 counts voted", nmodes * 16 + nregs, 3 * 16 + 4);
    chk(wr_cnt == 12, "R7 one write per entry", wr_cnt, 12);
    chk(seq_bad == 0, "R7 increasing index order", seq_bad, 0);
    for (int e = 0; e < 12; e++)
      chk(wr_val[e] == ev(e), $sformatf("R4 R5 entry %0d value", e), wr_val[e], ev(e));
    @(negedge clk);
    chk(!done, "R9 done one cycle", done, 0);
    chk(nmodes == 3, "R9 nmodes held", nmodes, 3);

    // both votes fail on entry 2 of a 1x4 table
    clear_mem();
    put_counts({8{8'h01}}, {8{8'h04}});
    fill_table(4);
    put_copies(2, 4, 0, 64'h8877665544332211);
    put_copies(2, 4, 1, 64'h1827364554637281);
    run_job();
    chk(error, "R6 abort on double failure", error, 1);
    chk(wr_cnt == 2, "R6 no writes after failure", wr_cnt, 2);
    repeat (3) @(negedge clk);
    chk(error, "R9 error held", error, 1);

    // overflow 9x8 = 72; also checks error clears on start
    clear_mem();
    put_counts({8{8'h09}}, {8{8'h08}});
    run_job();
    chk(!err_first, "R9 start clears error", err_first, 0);
    chk(error, "R8 overflow error", error, 1);
    chk(wr_cnt == 0, "R8 overflow no writes", wr_cnt, 0);

    // boundary 8x8 = 64 accepted
    clear_mem();
    put_counts({8{8'h08}}, {8{8'h08}});
    fill_table(64);
    run_job();
    chk(!error, "R8 product at limit accepted", error, 0);
    chk(wr_cnt == 64, "R7 all 64 written", wr_cnt, 64);
    chk(seq_bad == 0, "R7 order at limit", seq_bad, 0);
    begin
      int mism = 0;
      for (int e = 0; e < 64; e++) if (wr_val[e] != ev(e)) mism++;
      chk(mism == 0, "R4 values at limit", mism, 0);
    end

    // reset in the middle of a job
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (30) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!rd_en && !tbl_we && !done && !error, "R11 mid-job reset quiet", {rd_en, tbl_we, done, error}, 0);
    chk(nmodes == 0 && nregs == 0, "R11 mid-job reset counts", nmodes + nregs, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!rd_en, "R10 idle after reset release", rd_en, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule